// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sample Serial Output Sequencer

This block is the digital sequencer on the peripheral side of a two-channel converter that samples both channels at the same instant. It watches an active-low chip select and a serial clock, counts serial clock falling edges inside each frame, and decides when the two inputs are captured. It then sends them out on one serial data line, each result led by four zero bits and sent most significant bit first. The two 12-bit sample values arrive on parallel ports, which stand in for the conversion engines.

The serial lines are asynchronous to the block. They are brought into a faster system clock domain through two-stage synchronisers, and edges are detected from the synchronised values. The data line is modelled as a data bit plus an output enable. Three status outputs (acquire, convert, power-down) let a bench or a host follow the sequence edge by edge. If chip select stays low past the end of a frame, a new frame begins. If chip select rises, any frame in progress ends, and a rise before the sixteenth falling edge aborts it.

Top module: `sconv_seq`

## Requirements
- R1: `sdo_oe_o` is 1 exactly while the synchronised chip select is low and a frame is open. After chip select rises it returns to 0, and `sdo_o` reads 0 whenever `sdo_oe_o` is 0.
- R2: After serial clock falling edge k of a frame, `sdo_o` carries this bit: 0 for k = 1..4 and k = 17..20; bit (16-k) of channel A for k = 5..16; bit (32-k) of channel B for k = 21..32. Each channel is therefore sent MSB first.
- R3: `acquire_o` is 1 after falling edges 1, 2 and 3. Both channels are captured together on falling edge 4. `convert_o` is 1 from edge 4 until the serial clock rises after edge 32.
- R4: If chip select falls while the serial clock is low, that fall counts as falling edge 1. If it falls while the clock is high, the edge count stays 0 and all three status outputs are 0 until the next clock falling edge, which becomes edge 1.
- R5: With chip select held low, the falling edge after rising edge 32 is edge 1 of a new frame. That frame captures fresh inputs on its own edge 4 (absolute edge 36).
- R6: A chip select rise before edge 16 aborts the frame. The output is disabled and power-down is reported. The next chip select fall starts a fresh frame from edge 1 with new captured values.
- R7: `powerdown_o` is 1 while chip select is high. It is also 1 after the serial clock rises following edge 32, until the next falling edge. At most one of acquire, convert and power-down is 1 at any time.
- R8: The values on `chan_a_i` and `chan_b_i` are captured at the hold edge. Later changes do not alter the frame being sent.
- R9: A change on chip select reaches the outputs on the third rising system clock edge after it: two synchroniser stages plus one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Chip select, active low, asynchronous |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| chan_a_i | input | 12 | Channel A sample value |
| chan_b_i | input | 12 | Channel B sample value |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| acquire_o | output | 1 | Acquisition phase indicator |
| convert_o | output | 1 | Conversion phase indicator |
| powerdown_o | output | 1 | Power-down indicator |

## Verification
The bench builds the block with its default values: 12 result bits, 4 padding bits and two synchroniser stages. With these values the full 32-edge frame, the wrap to edge 33 in continuous mode and the edge-36 recapture can all be reached with short runs. The sample values are chosen so that both MSB and LSB states appear, including the two extremes 0x800 and 0x7FF. Inputs are changed between the hold edge and the end of the frame to show that capture happens only at the hold edge. Chip select falls both with the serial clock high and with it low, and one frame is aborted early, so every start condition is exercised.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_PAD  = 2'd1,
    SLOT_CHA  = 2'd2,
    SLOT_CHB  = 2'd3
  } slot_e;

  // Classify a falling-edge number (1-based) within a frame.
  function automatic slot_e slot_of(input int unsigned fe,
                                    input int unsigned pad_w,
                                    input int unsigned res_w);
    int unsigned half;
    int unsigned pos;
    half = pad_w + res_w;
    if (fe == 0 || fe > 2 * half) return SLOT_NONE;
    pos = (fe - 1) % half + 1;
    if (pos <= pad_w) return SLOT_PAD;
    return (fe > half) ? SLOT_CHB : SLOT_CHA;
  endfunction

  // Bit of the held word presented after falling edge fe (MSB first).
  function automatic int unsigned bit_of(input int unsigned fe,
                                         input int unsigned pad_w,
                                         input int unsigned res_w);
    int unsigned half;
    int unsigned pos;
    half = pad_w + res_w;
    if (fe == 0) return 0;
    pos = (fe - 1) % half + 1;
    if (pos <= pad_w) return 0;
    return half - pos;
  endfunction

endpackage

// File: rtl/sconv_sync.sv
module sconv_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sconv_edges.sv
module sconv_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_s,
  input  logic sck_s,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_fall,
  output logic sck_rise
);
  logic csn_d;
  logic sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      csn_d <= csn_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  =  csn_d && !csn_s;
  assign cs_rise  = !csn_d &&  csn_s;
  assign sck_fall =  sck_d && !sck_s;
  assign sck_rise = !sck_d &&  sck_s;
endmodule

// File: rtl/sconv_frame_ctr.sv
module sconv_frame_ctr #(
  parameter int unsigned PAD_BITS = 4,
  parameter int unsigned RES_BITS = 12,
  localparam int unsigned FRAME   = 2 * (PAD_BITS + RES_BITS),
  localparam int unsigned CW      = $clog2(FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csn_s,
  input  logic          sck_s,
  input  logic          cs_fall,
  input  logic          sck_fall,
  input  logic          sck_rise,
  output logic [CW-1:0] fcnt,
  output logic          in_frame,
  output logic          hold_stb,
  output logic          acquire,
  output logic          convert,
  output logic          powerdown
);
  localparam int unsigned HOLD_EDGE = PAD_BITS;

  logic tail;  // last bit sampled, waiting for the next frame

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt     <= '0;
      in_frame <= 1'b0;
      tail     <= 1'b0;
    end else if (csn_s) begin
      fcnt     <= '0;
      in_frame <= 1'b0;
      tail     <= 1'b0;
    end else if (cs_fall) begin
      in_frame <= 1'b1;
      tail     <= 1'b0;
      fcnt     <= sck_s ? '0 : CW'(1);
    end else if (in_frame) begin
      if (sck_fall) begin
        fcnt <= (fcnt == CW'(FRAME)) ? CW'(1) : fcnt + CW'(1);
        tail <= 1'b0;
      end else if (sck_rise && fcnt == CW'(FRAME)) begin
        tail <= 1'b1;
      end
    end
  end

  assign hold_stb  = in_frame && !csn_s && !cs_fall && sck_fall &&
                     (fcnt == CW'(HOLD_EDGE - 1));
  assign acquire   = in_frame && (fcnt != '0) && (fcnt < CW'(HOLD_EDGE));
  assign convert   = in_frame && (fcnt >= CW'(HOLD_EDGE)) && !tail;
  assign powerdown = !in_frame || tail;

  AST_CSLOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !sck_s) |=> (fcnt == CW'(1))); // R4
  AST_CSHIGH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && sck_s) |=> (fcnt == '0 && !acquire && !convert)); // R4
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !csn_s && !cs_fall && sck_fall && fcnt == CW'(FRAME))
      |=> (fcnt == CW'(1) && acquire)); // R5
  AST_DESELECT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> powerdown); // R7
endmodule

// File: rtl/sconv_hold_shift.sv
module sconv_hold_shift
  import sconv_pkg::*;
#(
  parameter int unsigned PAD_BITS = 4,
  parameter int unsigned RES_BITS = 12,
  localparam int unsigned FRAME   = 2 * (PAD_BITS + RES_BITS),
  localparam int unsigned CW      = $clog2(FRAME + 1),
  localparam int unsigned IW      = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_stb,
  input  logic                in_frame,
  input  logic [CW-1:0]       fcnt,
  input  logic [RES_BITS-1:0] chan_a,
  input  logic [RES_BITS-1:0] chan_b,
  output logic                sdo
);
  logic [RES_BITS-1:0] hold_a;
  logic [RES_BITS-1:0] hold_b;
  slot_e               slot;
  logic [IW-1:0]       idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else if (hold_stb) begin
      hold_a <= chan_a;
      hold_b <= chan_b;
    end
  end

  always_comb begin
    slot = slot_of(32'(fcnt), PAD_BITS, RES_BITS);
    idx  = IW'(bit_of(32'(fcnt), PAD_BITS, RES_BITS));
    sdo  = 1'b0;
    if (in_frame) begin
      case (slot)
        SLOT_CHA: sdo = hold_a[idx];
        SLOT_CHB: sdo = hold_b[idx];
        default:  sdo = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sconv_seq.sv
module sconv_seq #(
  parameter int unsigned PAD_BITS    = 4,
  parameter int unsigned RES_BITS    = 12,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FRAME      = 2 * (PAD_BITS + RES_BITS),
  localparam int unsigned CW         = $clog2(FRAME + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_i,
  input  logic                ser_clk_i,
  input  logic [RES_BITS-1:0] chan_a_i,
  input  logic [RES_BITS-1:0] chan_b_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic                acquire_o,
  output logic                convert_o,
  output logic                powerdown_o
);
  logic [1:0]    ser_s;
  logic          csn_s;
  logic          sck_s;
  logic          cs_fall;
  logic          cs_rise;
  logic          sck_fall;
  logic          sck_rise;
  logic [CW-1:0] fcnt;
  logic          in_frame;
  logic          hold_stb;
  logic          sdo_raw;

  sconv_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_n_i, ser_clk_i}),
    .q     (ser_s)
  );
  assign csn_s = ser_s[1];
  assign sck_s = ser_s[0];

  sconv_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (csn_s),
    .sck_s    (sck_s),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sck_fall (sck_fall),
    .sck_rise (sck_rise)
  );

  sconv_frame_ctr #(.PAD_BITS(PAD_BITS), .RES_BITS(RES_BITS)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_s     (csn_s),
    .sck_s     (sck_s),
    .cs_fall   (cs_fall),
    .sck_fall  (sck_fall),
    .sck_rise  (sck_rise),
    .fcnt      (fcnt),
    .in_frame  (in_frame),
    .hold_stb  (hold_stb),
    .acquire   (acquire_o),
    .convert   (convert_o),
    .powerdown (powerdown_o)
  );

  sconv_hold_shift #(.PAD_BITS(PAD_BITS), .RES_BITS(RES_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_stb (hold_stb),
    .in_frame (in_frame),
    .fcnt     (fcnt),
    .chan_a   (chan_a_i),
    .chan_b   (chan_b_i),
    .sdo      (sdo_raw)
  );

  assign sdo_oe_o = in_frame;
  assign sdo_o    = sdo_raw;

  AST_DESELECT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdo_oe_o && !sdo_o)); // R1
  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && fcnt != '0 && fcnt <= CW'(PAD_BITS)) |-> !sdo_o); // R2
  AST_HOLD_THEN_CONVERT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_stb |=> (convert_o && !acquire_o)); // R3
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (fcnt <= CW'(1) && sdo_oe_o)); // R6
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acquire_o, convert_o, powerdown_o})); // R7
endmodule

// File: tb/sconv_seq_bench.sv
module sconv_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        sck = 1'b1;
  logic [11:0] cha = '0;
  logic [11:0] chb = '0;
  logic        sdo, oe, acq, conv, pd;
  int          nchk = 0;
  int          nerr = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sconv_seq u_sconv_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n_i     (sel_n),
    .ser_clk_i   (sck),
    .chan_a_i    (cha),
    .chan_b_i    (chb),
    .sdo_o       (sdo),
    .sdo_oe_o    (oe),
    .acquire_o   (acq),
    .convert_o   (conv),
    .powerdown_o (pd)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected serial bit after falling edge k, from the frame layout (R2).
  function automatic logic want_bit(input int k, input logic [11:0] a,
                                    input logic [11:0] b);
    if (k >= 5 && k <= 16)  return a[16-k];
    if (k >= 21 && k <= 32) return b[32-k];
    return 1'b0;
  endfunction

  task automatic set_sck(input logic v);
    @(negedge clk) sck = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk) sel_n = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_edge(input int k, input logic [11:0] a,
                            input logic [11:0] b, input string req);
    chk(req, $sformatf("R2 bit edge %0d", k), 32'(sdo), 32'(want_bit(k, a, b)));
    chk(req, $sformatf("R3 acquire edge %0d", k), 32'(acq), 32'(k <= 3));
    chk(req, $sformatf("R3 convert edge %0d", k), 32'(conv), 32'(k >= 4));
    chk(req, $sformatf("R7 powerdown edge %0d", k), 32'(pd), 32'(0));
    chk(req, $sformatf("R1 enable edge %0d", k), 32'(oe), 32'(1));
  endtask

  task automatic test_reset();
    chk("R1", "enable after reset", 32'(oe), 32'(0));
    chk("R1", "data after reset", 32'(sdo), 32'(0));
    chk("R7", "powerdown after reset", 32'(pd), 32'(1));
    chk("R7", "acquire after reset", 32'(acq), 32'(0));
    chk("R7", "convert after reset", 32'(conv), 32'(0));
  endtask

  // Chip select falls with the serial clock high; inputs move after hold.
  task automatic test_single_high();
    logic [11:0] a = 12'hA5C;
    logic [11:0] b = 12'h3F1;
    cha = a; chb = b;
    set_sck(1'b1);
    @(negedge clk) sel_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "enable two clocks after select", 32'(oe), 32'(0));
    @(negedge clk);
    chk("R9", "enable three clocks after select", 32'(oe), 32'(1));
    repeat (4) @(negedge clk);
    chk("R4", "no acquire before first fall", 32'(acq), 32'(0));
    chk("R4", "no convert before first fall", 32'(conv), 32'(0));
    chk("R7", "not powered down when selected", 32'(pd), 32'(0));
    for (int k = 1; k <= 32; k++) begin
      set_sck(1'b0);
      check_edge(k, a, b, "R2");
      if (k == 4) begin
        cha = 12'h123; chb = 12'hFED;  // R8: must not reach this frame
      end
      if (k == 10) chk("R8", "held A bit after input change", 32'(sdo), 32'(a[6]));
      set_sck(1'b1);
    end
    chk("R7", "powerdown after last rise", 32'(pd), 32'(1));
    chk("R3", "convert ends after last rise", 32'(conv), 32'(0));
    set_cs(1'b1);
    chk("R1", "enable after deselect", 32'(oe), 32'(0));
    chk("R1", "data after deselect", 32'(sdo), 32'(0));
    chk("R7", "powerdown after deselect", 32'(pd), 32'(1));
  endtask

  // Chip select falls with the serial clock low: that fall is edge 1.
  task automatic test_single_low();
    logic [11:0] a = 12'h800;
    logic [11:0] b = 12'h7FF;
    cha = a; chb = b;
    set_sck(1'b0);
    set_cs(1'b0);
    chk("R4", "select fall counts as edge 1 (acquire)", 32'(acq), 32'(1));
    check_edge(1, a, b, "R4");
    for (int k = 2; k <= 32; k++) begin
      set_sck(1'b1);
      set_sck(1'b0);
      check_edge(k, a, b, "R4");
    end
    set_sck(1'b1);
    chk("R7", "powerdown after last rise (low start)", 32'(pd), 32'(1));
    set_cs(1'b1);
  endtask

  // Two frames back to back with chip select held low.
  task automatic test_continuous();
    logic [11:0] a1 = 12'h0F3;
    logic [11:0] b1 = 12'hC81;
    logic [11:0] a2 = 12'h9E6;
    logic [11:0] b2 = 12'h25A;
    cha = a1; chb = b1;
    set_sck(1'b1);
    set_cs(1'b0);
    for (int f = 0; f < 2; f++) begin
      for (int k = 1; k <= 32; k++) begin
        set_sck(1'b0);
        check_edge(k, (f == 0) ? a1 : a2, (f == 0) ? b1 : b2, "R5");
        if (f == 0 && k == 10) begin
          cha = a2; chb = b2;
        end
        set_sck(1'b1);
      end
      chk("R7", $sformatf("powerdown between frames %0d", f), 32'(pd), 32'(1));
      chk("R5", $sformatf("enable kept after frame %0d", f), 32'(oe), 32'(1));
    end
    set_cs(1'b1);
  endtask

  // Abort at edge 10, then a fresh frame with new values.
  task automatic test_abort();
    logic [11:0] a = 12'h5A5;
    logic [11:0] b = 12'hA5A;
    logic [11:0] a2 = 12'h0F0;
    logic [11:0] b2 = 12'hF0F;
    cha = a; chb = b;
    set_sck(1'b1);
    set_cs(1'b0);
    for (int k = 1; k <= 10; k++) begin
      set_sck(1'b0);
      check_edge(k, a, b, "R6");
      set_sck(1'b1);
    end
    set_cs(1'b1);
    chk("R6", "enable after abort", 32'(oe), 32'(0));
    chk("R6", "data after abort", 32'(sdo), 32'(0));
    chk("R6", "powerdown after abort", 32'(pd), 32'(1));
    chk("R6", "convert after abort", 32'(conv), 32'(0));
    cha = a2; chb = b2;
    set_cs(1'b0);
    chk("R6", "fresh frame waits for edge 1", 32'(acq), 32'(0));
    for (int k = 1; k <= 32; k++) begin
      set_sck(1'b0);
      check_edge(k, a2, b2, "R6");
      set_sck(1'b1);
    end
    set_cs(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    test_reset();
    test_single_high();
    test_single_low();
    test_continuous();
    test_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule